// File: doc/BRIEF.md
# Reachability Marking Engine for an Object Heap

This block does the marking half of a hardware collector. It sets a live mark on every object that can be reached from a snapshot of register-file roots. It walks a small on-chip object heap breadth-first. A short work queue holds the objects it has discovered but not yet scanned. The engine reads heap words through a synchronous read port. Each read also returns the metadata entry of the word pair that holds the addressed word. A word counts as an edge only when its metadata says it holds a valid pointer.

Software or a controller supplies the root values and a selection mask, then pulses `start`. The engine reports each newly marked object on `mark_valid`/`mark_addr`. When no work remains it pulses `done` and holds the total on `mark_count`. The work queue is deliberately shallow. When it fills, the engine remembers the objects it could not queue and scans them again in later passes. It repeats this until a pass finishes without dropping anything.

Top module: `mark_engine`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `mark_valid` are low, and no heap read is issued until `start`.
- R2: A pulse on `start` while idle captures all root values and the root mask. Every root whose mask bit is 1 and that passes the follow rule of R3 is marked. A root whose mask bit is 0 is ignored.
- R3: A pointer holds the object length in words in bits [63:50], a canonical flag in bit 49 and the address in bits [47:0]. It is followed only when the length is at least 2, address bits [47:ADDR_W] equal those of `PAD_BASE`, and the low ADDR_W address bits plus the length are at most 2^ADDR_W. Canonical and non-canonical pointers are treated alike.
- R4: The metadata entry of word address a is entry a>>1. In that entry bit 0 is valid, bit 1 is dirty and has no effect, bit 2 flags the even word of the pair as a pointer and bit 3 flags the odd word. A word is an edge only when valid and its own flag are both 1.
- R5: Only words 1 to length-1 of an object are examined. Word 0, the header, is never followed, even when its flag is set.
- R6: Each object is reported on `mark_valid` at most once per run, so cyclic and self-referencing structures terminate.
- R7: When the work queue is full, a newly found object is still marked and is remembered. After the queue drains, the remembered objects are rescanned, taking their length from header bits [13:0], until a pass drops nothing. The final marked set is the full reachable set.
- R8: When all work is done, `done` is high for exactly one cycle. In that cycle `busy` is low, and `mark_count` equals the number of `mark_valid` reports in the run.
- R9: A `start` pulse while `busy` is high is ignored and does not change the roots or the result of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a marking run when idle |
| root_ptrs | input | N_ROOTS*64 | Register-file snapshot, root i in bits [64*i+63:64*i] |
| root_sel | input | N_ROOTS | Mask of roots that hold pointers |
| mem_re | output | 1 | Heap read strobe |
| mem_addr | output | ADDR_W | Heap word address |
| mem_rdata | input | 64 | Heap word, one cycle after `mem_re` |
| meta_rdata | input | 4 | Metadata of the pair holding `mem_addr`, one cycle after `mem_re` |
| mark_valid | output | 1 | An object was newly marked |
| mark_addr | output | ADDR_W | Header address of the marked object |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| mark_count | output | ADDR_W+1 | Objects marked in the last run |

## Verification
A candidate pointer is decided in the cycle its word returns, one cycle after the read. Its mark report appears on `mark_valid` one cycle after that. A root is reported the cycle after it is examined, so the first report follows `start` by two cycles. The bench samples on the falling edge. On every cycle it matches each mark report against a behaviourally computed reachable set, and on each report it checks for duplicates, so the report latency need not be predicted exactly. `done` is due the cycle after the queue is seen empty with no read outstanding. The bench waits for it with a bound, checks the count and the busy level in that cycle, and checks that `done` has fallen one cycle later.

// File: rtl/gc_mark_pkg.sv
// Shared field positions and types for the marking engine.
// Assumes 64-bit heap words and the pointer layout given in the brief.
package gc_mark_pkg;
    localparam int WORD_W       = 64;
    localparam int SIZE_W       = 14;
    localparam int SIZE_LSB     = 50;
    localparam int PADDR_W      = 48;
    localparam int META_W       = 4;
    localparam int META_VALID   = 0;
    localparam int META_DIRTY   = 1;
    localparam int META_PE      = 2;
    localparam int META_PO      = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROOTS,
        ST_POP,
        ST_WALK,
        ST_SWEEP,
        ST_HDR
    } eng_state_t;
endpackage

// File: rtl/mark_ptr_decode.sv
// Splits a pointer into address and length and decides whether it may be
// followed inside this heap's partition. Purely combinational.
// Assumes ADDR_W <= 14.
module mark_ptr_decode
    import gc_mark_pkg::*;
#(
    parameter int          ADDR_W   = 10,
    parameter logic [47:0] PAD_BASE = 48'h400
) (
    input  logic [WORD_W-1:0] ptr,
    output logic              follow,
    output logic [ADDR_W-1:0] obj_addr,
    output logic [SIZE_W-1:0] obj_size
);
    localparam int HEAP_WORDS = 1 << ADDR_W;
    localparam int SUM_W      = ((ADDR_W > SIZE_W) ? ADDR_W : SIZE_W) + 1;

    logic [SUM_W-1:0] end_word;
    logic             tag_ok;
    logic [1:0]       unused_flags;

    // Decode fields and test the partition, length and heap-bound rules.
    always_comb begin
        obj_size     = ptr[SIZE_LSB +: SIZE_W];
        obj_addr     = ptr[ADDR_W-1:0];
        tag_ok       = (ptr[PADDR_W-1:ADDR_W] == PAD_BASE[PADDR_W-1:ADDR_W]);
        end_word     = SUM_W'(obj_addr) + SUM_W'(obj_size);
        follow       = tag_ok && (obj_size >= SIZE_W'(2)) &&
                       (end_word <= SUM_W'(HEAP_WORDS));
        unused_flags = ptr[49:48];
    end
endmodule

// File: rtl/mark_fifo.sv
// Work queue of discovered objects. Head is visible combinationally.
// Assumes DEPTH is a power of two and the user never pushes when full
// or pops when empty; clear empties it in one cycle.
module mark_fifo #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  fill;

    assign head  = store[rd_ptr];
    assign empty = (fill == '0);
    assign full  = (fill == CNT_W'(DEPTH));

    // Write incoming entries into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_data;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (push && !pop)      fill <= fill + 1'b1;
            else if (pop && !push) fill <= fill - 1'b1;
        end
    end

    // R7: overflow must be diverted by the engine, never pushed.
    p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !clear));
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty && !clear));
endmodule

// File: rtl/mark_bitmap.sv
// Per-word live and pending bitmaps. A bit is indexed by an object's
// header address. Pending bits record objects marked while the work
// queue was full. Clear wipes both maps in one cycle.
module mark_bitmap #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              set_mark,
    input  logic [ADDR_W-1:0] mark_idx,
    output logic              is_marked,
    input  logic              pend_set,
    input  logic              pend_clr,
    input  logic [ADDR_W-1:0] pend_clr_idx,
    input  logic [ADDR_W-1:0] pend_qry_idx,
    output logic              is_pending
);
    localparam int HEAP_WORDS = 1 << ADDR_W;

    logic [HEAP_WORDS-1:0] live_q;
    logic [HEAP_WORDS-1:0] pend_q;

    assign is_marked  = live_q[mark_idx];
    assign is_pending = pend_q[pend_qry_idx];

    // Record live marks for newly reached objects.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            live_q <= '0;
        end else if (set_mark) begin
            live_q[mark_idx] <= 1'b1;
        end
    end

    // Record and retire objects that still need their children scanned.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_q <= '0;
        end else begin
            if (pend_set) pend_q[mark_idx]     <= 1'b1;
            if (pend_clr) pend_q[pend_clr_idx] <= 1'b0;
        end
    end

    // R6: an object already live is never marked a second time.
    p_mark_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mark && !clear) |-> !live_q[mark_idx]);
    // R7: only live objects are ever rescanned from the pending map.
    p_pend_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !clear) |-> live_q[pend_clr_idx]);
endmodule

// File: rtl/mark_engine.sv
// Breadth-first marking engine. Loads roots, walks objects through a
// one-cycle-latency read port, marks reachable objects and rescans objects
// dropped on queue overflow. Assumes the heap is stable during a run and
// that each object's header bits [13:0] hold its length.
module mark_engine
    import gc_mark_pkg::*;
#(
    parameter int          ADDR_W     = 10,
    parameter int          N_ROOTS    = 8,
    parameter int          FIFO_DEPTH = 4,
    parameter logic [47:0] PAD_BASE   = 48'h400
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [N_ROOTS*WORD_W-1:0]   root_ptrs,
    input  logic [N_ROOTS-1:0]          root_sel,
    output logic                        mem_re,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic [WORD_W-1:0]           mem_rdata,
    input  logic [META_W-1:0]           meta_rdata,
    output logic                        mark_valid,
    output logic [ADDR_W-1:0]           mark_addr,
    output logic                        busy,
    output logic                        done,
    output logic [ADDR_W:0]             mark_count
);
    localparam int HEAP_WORDS = 1 << ADDR_W;
    localparam int ENT_W      = ADDR_W + SIZE_W;
    localparam int RIDX_W     = (N_ROOTS > 1) ? $clog2(N_ROOTS) : 1;
    localparam int SWP_W      = ADDR_W + 1;

    eng_state_t                    state;
    logic [N_ROOTS-1:0][WORD_W-1:0] roots_q;
    logic [N_ROOTS-1:0]            sel_q;
    logic [RIDX_W-1:0]             root_idx;
    logic [ADDR_W-1:0]             cur_addr;
    logic [SIZE_W-1:0]             cur_size;
    logic [SIZE_W-1:0]             word_idx;
    logic                          rsp_valid;
    logic                          rsp_odd;
    logic                          ovf_q;
    logic [SWP_W-1:0]              sweep_idx;

    logic [WORD_W-1:0]             cand_ptr;
    logic                          cand_en;
    logic                          cand_hit;
    logic                          dec_follow;
    logic [ADDR_W-1:0]             dec_addr;
    logic [SIZE_W-1:0]             dec_size;
    logic                          bm_marked;
    logic                          bm_pending;
    logic                          fifo_push;
    logic                          fifo_pop;
    logic                          fifo_clear;
    logic                          fifo_empty;
    logic                          fifo_full;
    logic [ENT_W-1:0]              fifo_in;
    logic [ENT_W-1:0]              fifo_head;
    logic [SIZE_W-1:0]             hdr_size;
    logic [ADDR_W-1:0]             walk_addr;
    logic [ADDR_W-1:0]             sweep_addr;
    logic                          sweep_live;
    logic                          unused_dirty;

    assign busy         = (state != ST_IDLE);
    assign sweep_addr   = sweep_idx[ADDR_W-1:0];
    assign sweep_live   = !sweep_idx[ADDR_W];
    assign walk_addr    = cur_addr + ADDR_W'(word_idx);
    assign unused_dirty = meta_rdata[META_DIRTY];

    // Pick the pointer under test: a root, or a returned heap word.
    always_comb begin
        if (state == ST_ROOTS) begin
            cand_ptr = roots_q[root_idx];
            cand_en  = sel_q[root_idx];
        end else begin
            cand_ptr = mem_rdata;
            cand_en  = rsp_valid && meta_rdata[META_VALID] &&
                       (rsp_odd ? meta_rdata[META_PO] : meta_rdata[META_PE]);
        end
        cand_hit = cand_en && dec_follow && !bm_marked;
    end

    mark_ptr_decode #(
        .ADDR_W   (ADDR_W),
        .PAD_BASE (PAD_BASE)
    ) dec_i (
        .ptr      (cand_ptr),
        .follow   (dec_follow),
        .obj_addr (dec_addr),
        .obj_size (dec_size)
    );

    // Queue length for a rescanned object, never below two words.
    always_comb begin
        hdr_size = mem_rdata[SIZE_W-1:0];
        if (hdr_size < SIZE_W'(2)) hdr_size = SIZE_W'(2);
    end

    // Work-queue controls: enqueue new finds or rescans, dequeue to walk.
    always_comb begin
        fifo_clear = (state == ST_IDLE) && start;
        fifo_pop   = (state == ST_POP) && !fifo_empty;
        if (state == ST_HDR) begin
            fifo_push = 1'b1;
            fifo_in   = {sweep_addr, hdr_size};
        end else begin
            fifo_push = cand_hit && !fifo_full;
            fifo_in   = {dec_addr, dec_size};
        end
    end

    // Heap read requests for object walks and header fetches.
    always_comb begin
        mem_re   = 1'b0;
        mem_addr = walk_addr;
        if (state == ST_WALK) begin
            mem_re = 1'b1;
        end else if (state == ST_SWEEP && sweep_live && bm_pending && !fifo_full) begin
            mem_re   = 1'b1;
            mem_addr = sweep_addr;
        end
    end

    mark_fifo #(
        .DATA_W (ENT_W),
        .DEPTH  (FIFO_DEPTH)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (fifo_clear),
        .push      (fifo_push),
        .push_data (fifo_in),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    mark_bitmap #(
        .ADDR_W (ADDR_W)
    ) bmap_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (fifo_clear),
        .set_mark     (cand_hit),
        .mark_idx     (dec_addr),
        .is_marked    (bm_marked),
        .pend_set     (cand_hit && fifo_full),
        .pend_clr     (state == ST_HDR),
        .pend_clr_idx (sweep_addr),
        .pend_qry_idx (sweep_addr),
        .is_pending   (bm_pending)
    );

    // Sequence root loading, walking, rescans and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            roots_q   <= '0;
            sel_q     <= '0;
            root_idx  <= '0;
            cur_addr  <= '0;
            cur_size  <= '0;
            word_idx  <= '0;
            ovf_q     <= 1'b0;
            sweep_idx <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cand_hit && fifo_full) ovf_q <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        roots_q  <= root_ptrs;
                        sel_q    <= root_sel;
                        root_idx <= '0;
                        ovf_q    <= 1'b0;
                        state    <= ST_ROOTS;
                    end
                end
                ST_ROOTS: begin
                    root_idx <= root_idx + 1'b1;
                    if (root_idx == RIDX_W'(N_ROOTS - 1)) state <= ST_POP;
                end
                ST_POP: begin
                    if (!fifo_empty) begin
                        cur_addr <= fifo_head[ENT_W-1:SIZE_W];
                        cur_size <= fifo_head[SIZE_W-1:0];
                        word_idx <= SIZE_W'(1);
                        state    <= ST_WALK;
                    end else if (!rsp_valid) begin
                        if (ovf_q) begin
                            ovf_q     <= 1'b0;
                            sweep_idx <= '0;
                            state     <= ST_SWEEP;
                        end else begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_WALK: begin
                    word_idx <= word_idx + 1'b1;
                    if (word_idx == cur_size - 1'b1) state <= ST_POP;
                end
                ST_SWEEP: begin
                    if (!sweep_live) begin
                        state <= ST_POP;
                    end else if (bm_pending) begin
                        if (fifo_full) begin
                            ovf_q <= 1'b1;
                            state <= ST_POP;
                        end else begin
                            state <= ST_HDR;
                        end
                    end else begin
                        sweep_idx <= sweep_idx + 1'b1;
                    end
                end
                ST_HDR: begin
                    sweep_idx <= sweep_idx + 1'b1;
                    state     <= ST_SWEEP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Track which read returns a pointer candidate and its word parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_odd   <= 1'b0;
        end else begin
            rsp_valid <= (state == ST_WALK);
            rsp_odd   <= walk_addr[0];
        end
    end

    // Report marks and keep the per-run tally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_valid <= 1'b0;
            mark_addr  <= '0;
            mark_count <= '0;
        end else begin
            mark_valid <= cand_hit;
            mark_addr  <= dec_addr;
            if (fifo_clear)    mark_count <= '0;
            else if (cand_hit) mark_count <= mark_count + 1'b1;
        end
    end

    // R8: completion is a single-cycle pulse seen only once idle.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: a start during a run does not end or restart it.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (mark_count >= $past(mark_count)));
    // R1: no heap traffic while idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_re);
endmodule

// File: tb/mark_engine_tb_top.sv
module mark_engine_tb_top;
    localparam int          AW   = 10;
    localparam int          NR   = 8;
    localparam int          HW   = 1 << AW;
    localparam logic [47:0] PB   = 48'h400;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [NR*64-1:0]   root_ptrs = '0;
    logic [NR-1:0]      root_sel = '0;
    logic               mem_re;
    logic [AW-1:0]      mem_addr;
    logic [63:0]        mem_rdata = '0;
    logic [3:0]         meta_rdata = '0;
    logic               mark_valid;
    logic [AW-1:0]      mark_addr;
    logic               busy;
    logic               done;
    logic [AW:0]        mark_count;

    logic [63:0] heap [HW];
    logic [3:0]  meta [HW/2];
    bit          exp_mark [HW];
    bit          seen [HW];
    int          exp_count;
    int          seen_count;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    bit          monitor_on = 1'b0;
    string       cur_tag = "R1";

    always #5 clk = ~clk;

    mark_engine #(
        .ADDR_W (AW), .N_ROOTS (NR), .FIFO_DEPTH (4), .PAD_BASE (PB)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start),
        .root_ptrs (root_ptrs), .root_sel (root_sel),
        .mem_re (mem_re), .mem_addr (mem_addr),
        .mem_rdata (mem_rdata), .meta_rdata (meta_rdata),
        .mark_valid (mark_valid), .mark_addr (mark_addr),
        .busy (busy), .done (done), .mark_count (mark_count)
    );

    // Heap model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_re) begin
            mem_rdata  <= heap[mem_addr];
            meta_rdata <= meta[mem_addr >> 1];
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: R8 actual=no completion expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Every-clock comparison of mark reports against the reference set (R6).
    always @(negedge clk) begin
        if (monitor_on && mark_valid) begin
            checks = checks + 1;
            if (!exp_mark[mark_addr] || seen[mark_addr]) begin
                errors = errors + 1;
                $display("FAIL %s R6 mark at %0d: actual reachable=%0d dup=%0d expected reachable=1 dup=0",
                         cur_tag, mark_addr, exp_mark[mark_addr], seen[mark_addr]);
            end
            seen[mark_addr] = 1'b1;
            seen_count = seen_count + 1;
        end
    end

    function automatic logic [63:0] mkptr(int addr, int size, bit canon);
        logic [63:0] p;
        p = '0;
        p[63:50] = 14'(size);
        p[49]    = canon;
        p[47:0]  = PB | 48'(addr);
        return p;
    endfunction

    function automatic bit bfollow(logic [63:0] p);
        int sz;
        int lo;
        sz = int'(p[63:50]);
        lo = int'(p[AW-1:0]);
        return (p[47:AW] == PB[47:AW]) && (sz >= 2) && (lo + sz <= HW);
    endfunction

    task automatic wipe();
        for (int i = 0; i < HW; i++) heap[i] = '0;
        for (int i = 0; i < HW/2; i++) meta[i] = '0;
        root_ptrs = '0;
        root_sel  = '0;
    endtask

    task automatic put_obj(int addr, int size);
        heap[addr] = 64'(size);
        for (int w = 0; w < size; w++) meta[(addr + w) >> 1][0] = 1'b1;
    endtask

    task automatic put_ptr(int word, logic [63:0] val, bit flag);
        heap[word] = val;
        meta[word >> 1][0] = 1'b1;
        if (flag) meta[word >> 1][2 + (word & 1)] = 1'b1;
    endtask

    task automatic set_root(int i, logic [63:0] val, bit sel);
        root_ptrs[i*64 +: 64] = val;
        root_sel[i] = sel;
    endtask

    // Behavioural breadth-first reference over the bench heap.
    task automatic compute_ref();
        int q[$];
        int sz[$];
        logic [63:0] p;
        for (int i = 0; i < HW; i++) begin
            exp_mark[i] = 1'b0;
            seen[i] = 1'b0;
        end
        exp_count = 0;
        seen_count = 0;
        for (int r = 0; r < NR; r++) begin
            p = root_ptrs[r*64 +: 64];
            if (root_sel[r] && bfollow(p) && !exp_mark[int'(p[AW-1:0])]) begin
                exp_mark[int'(p[AW-1:0])] = 1'b1;
                exp_count++;
                q.push_back(int'(p[AW-1:0]));
                sz.push_back(int'(p[63:50]));
            end
        end
        while (q.size() > 0) begin
            int a;
            int s;
            a = q.pop_front();
            s = sz.pop_front();
            for (int w = 1; w < s; w++) begin
                int wa;
                logic [3:0] m;
                wa = a + w;
                m = meta[wa >> 1];
                p = heap[wa];
                if (m[0] && m[2 + (wa & 1)] && bfollow(p) && !exp_mark[int'(p[AW-1:0])]) begin
                    exp_mark[int'(p[AW-1:0])] = 1'b1;
                    exp_count++;
                    q.push_back(int'(p[AW-1:0]));
                    sz.push_back(int'(p[63:50]));
                end
            end
        end
    endtask

    task automatic check(bit ok, string what, int act, int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", cur_tag, what, act, exp);
        end
    endtask

    // Run one marking pass; optionally pulse start again mid-run (R9).
    task automatic run_case(string tag, bit restart);
        int waited;
        cur_tag = tag;
        compute_ref();
        monitor_on = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "busy after start", int'(busy), 1);
        if (restart) begin
            root_sel = '1;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 50000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1 && busy == 1'b0, "R8 done while idle", int'({done, busy}), 2);
        check(int'(mark_count) == exp_count, "R8 mark_count", int'(mark_count), exp_count);
        check(seen_count == exp_count, "R7 reports seen", seen_count, exp_count);
        @(negedge clk);
        check(done == 1'b0, "R8 done one cycle", int'(done), 0);
        monitor_on = 1'b0;
    endtask

    initial begin
        wipe();
        for (int i = 0; i < HW; i++) begin
            exp_mark[i] = 1'b0;
            seen[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(!busy && !done && !mark_valid && !mem_re, "R1 in reset", int'({busy, done, mark_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done && !mark_valid && !mem_re, "R1 after reset", int'({busy, done, mark_valid}), 0);

        // R2 R5: chain plus a stack-pointer root.
        wipe();
        put_obj(10, 4); put_obj(20, 2); put_obj(30, 3); put_obj(40, 2);
        put_ptr(12, mkptr(20, 2, 1'b1), 1'b1);
        put_ptr(13, 64'h1234, 1'b0);
        put_ptr(21, mkptr(30, 3, 1'b1), 1'b1);
        set_root(0, mkptr(10, 4, 1'b1), 1'b1);
        set_root(7, mkptr(40, 2, 1'b1), 1'b1);
        run_case("R2", 1'b0);
        check(exp_count == 4, "R2 reference size", exp_count, 4);

        // R6: mutual and self references.
        wipe();
        put_obj(10, 2); put_obj(20, 3);
        put_ptr(11, mkptr(20, 3, 1'b0), 1'b1);
        put_ptr(21, mkptr(10, 2, 1'b1), 1'b1);
        put_ptr(22, mkptr(20, 3, 1'b1), 1'b1);
        set_root(0, mkptr(10, 2, 1'b1), 1'b1);
        set_root(1, mkptr(20, 3, 1'b0), 1'b1);
        run_case("R6", 1'b0);

        // R4 R5: unflagged word, invalid pair, header flag, dirty bit.
        wipe();
        put_obj(10, 6); put_obj(50, 2); put_obj(60, 2); put_obj(70, 2); put_obj(90, 2);
        put_ptr(10, mkptr(70, 2, 1'b1), 1'b1);
        put_ptr(11, mkptr(50, 2, 1'b1), 1'b0);
        put_ptr(12, mkptr(60, 2, 1'b1), 1'b1);
        meta[6][0] = 1'b0;
        put_ptr(15, mkptr(90, 2, 1'b1), 1'b1);
        meta[7][1] = 1'b1;
        set_root(2, mkptr(10, 6, 1'b1), 1'b1);
        run_case("R4", 1'b0);
        check(exp_count == 2, "R5 header/flags reference", exp_count, 2);

        // R3 R2: canonical flag, partition, length, bound, unselected root.
        wipe();
        put_obj(10, 2); put_obj(20, 2); put_obj(30, 2); put_obj(40, 2); put_obj(50, 2);
        set_root(0, mkptr(10, 2, 1'b1), 1'b1);
        set_root(1, mkptr(20, 2, 1'b0), 1'b1);
        set_root(2, mkptr(30, 2, 1'b1) ^ 64'h0000_0000_0800, 1'b1);
        set_root(3, mkptr(40, 1, 1'b1), 1'b1);
        set_root(4, mkptr(1020, 8, 1'b1), 1'b1);
        set_root(5, mkptr(50, 2, 1'b1), 1'b0);
        run_case("R3", 1'b0);
        check(exp_count == 2, "R3 reference size", exp_count, 2);

        // R7: fan-out beyond the queue depth.
        wipe();
        put_obj(100, 13);
        for (int i = 0; i < 12; i++) begin
            put_obj(200 + 4*i, 3);
            put_obj(300 + 2*i, 2);
            put_ptr(101 + i, mkptr(200 + 4*i, 3, 1'b1), 1'b1);
            put_ptr(201 + 4*i, mkptr(300 + 2*i, 2, 1'b1), 1'b1);
        end
        set_root(0, mkptr(100, 13, 1'b1), 1'b1);
        run_case("R7", 1'b0);
        check(exp_count == 25, "R7 reference size", exp_count, 25);

        // R9: second start mid-run must not widen the root set.
        wipe();
        put_obj(10, 4); put_obj(20, 2); put_obj(40, 2);
        put_ptr(12, mkptr(20, 2, 1'b1), 1'b1);
        set_root(0, mkptr(10, 4, 1'b1), 1'b1);
        set_root(6, mkptr(40, 2, 1'b1), 1'b0);
        run_case("R9", 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule